// File: doc/BRIEF.md
# Dual Phase-Frequency Detector with Lock Qualifier

This block holds two digital phase/frequency detectors. One serves the main loop and one the auxiliary loop. Both run synchronously on the reference input clock. Each detector watches a divided reference pulse and a divided VCO (feedback) pulse, which idle high and mark an event by going low. A falling reference pulse raises the "up" enable, which asks the charge pump to push the VCO faster. A falling feedback pulse raises the "down" enable. The pair clears only after both have been set and one extra reference cycle has passed. That overlap removes the dead band near zero phase error.

Each channel also checks every comparison. It counts the cycles in which exactly one of its enables was high, and a run of narrow comparisons declares the channel locked. The shared lock output is the AND of both channels, and a disabled channel always counts as locked. The main channel also produces a three-cycle window around its reference event, which times the fractional ripple compensation. A speed-up flag is set when a main-divider word is loaded while the strobe is high, and it gates the integral charge-pump enables. The analog pumps and current DACs sit outside this block.

Top module: `dual_pfd_lock`

## Requirements
- R1: A divider reference pulse that is sampled high at one clock edge and low at the next edge k makes that channel's up output go high after edge k+1. Up stays high until the pair clears.
- R2: A feedback pulse falling in the same sense makes that channel's down output go high after edge k+1. Down stays high until the pair clears.
- R3: Once up and down are both high, both stay high for exactly two cycles and then drop together at the following edge, provided no new falling edge arrives meanwhile.
- R4: While a channel's enable is low, its up and down outputs are low from the next edge onward. Its lock history is discarded.
- R5: A comparison passes when the number of cycles with exactly one of up/down high since the previous clear is at most LOCK_TOL (default 1).
- R6: A channel's lock flag sets at the edge that ends the clear cycle of its LOCK_RUNS-th (default 2) consecutive passing comparison. It drops at the edge that ends the clear cycle of a failing comparison.
- R7: The lock output is the AND of the two channel flags. A channel whose enable is low counts as locked at once.
- R8: With the main channel enabled, the compensation window is high for the three cycles that follow edges k, k+1 and k+2, where k is the edge that first samples the main reference pulse low.
- R9: Speed-up sets at an edge that samples both the load pulse and the strobe high. It stays set while the strobe is high and clears at the first edge that samples the strobe low. A load pulse while the strobe is low has no effect.
- R10: The integral up/down enables copy the main up/down outputs while speed-up is high and are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_en | input | 1 | Main channel enable |
| aux_en | input | 1 | Auxiliary channel enable |
| main_ref_div | input | 1 | Main divided reference pulse, active low |
| main_fb_div | input | 1 | Main divided VCO pulse, active low |
| aux_ref_div | input | 1 | Auxiliary divided reference pulse, active low |
| aux_fb_div | input | 1 | Auxiliary divided VCO pulse, active low |
| a_word_load | input | 1 | One-cycle pulse: main divider word loaded |
| strobe | input | 1 | Serial strobe level |
| main_up | output | 1 | Main proportional pump up enable |
| main_dn | output | 1 | Main proportional pump down enable |
| main_int_up | output | 1 | Main integral pump up enable |
| main_int_dn | output | 1 | Main integral pump down enable |
| aux_up | output | 1 | Auxiliary pump up enable |
| aux_dn | output | 1 | Auxiliary pump down enable |
| speedup | output | 1 | Speed-up mode flag |
| comp_win | output | 1 | Fractional compensation window |
| lock | output | 1 | Combined lock indication |

## Verification
The window and overlap properties assume that falling edges on one channel's two divider pulses are at least four cycles apart from the next pair. This ensures a new event never lands on the cycle in which the pair clears. The stimulus keeps that spacing by sending pulses that are two cycles low once per sixteen-cycle period, with phase offsets of at most a few cycles. The one frequency-error case puts its second reference pulse well away from the feedback pulse. The enables, strobe and load pulse change only half a cycle after an edge, so every input is stable when sampled.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   localparam int NUM_CH  = 2;
   localparam int CH_MAIN = 0;
   localparam int CH_AUX  = 1;

   typedef struct packed {
      logic up;
      logic dn;
   } pump_t;
endpackage

// File: rtl/pfd_fall_tap.sv
module pfd_fall_tap (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   output logic early_o
);
   logic s_now, s_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_now <= 1'b1;
         s_old <= 1'b1;
      end else begin
         s_now <= pulse_i;
         s_old <= s_now;
      end
   end

   // one-cycle strobe after the edge that first samples the pulse low
   assign early_o = s_old & ~s_now;
endmodule

// File: rtl/pfd_flop_pair.sv
module pfd_flop_pair #(
   parameter int LOCK_TOL = 1,
   parameter bit HAS_WIN  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ref_early,
   input  logic fb_early,
   output logic up_o,
   output logic dn_o,
   output logic done_o,
   output logic width_ok_o,
   output logic win_o
);
   localparam int CNT_W = $clog2(LOCK_TOL + 2);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LOCK_TOL + 1);
   localparam logic [CNT_W-1:0] CNT_TOL = CNT_W'(LOCK_TOL);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             up_q, dn_q, clr_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q  <= 1'b0;
         dn_q  <= 1'b0;
         clr_q <= 1'b0;
         cnt_q <= '0;
      end else if (!en) begin
         up_q  <= 1'b0;
         dn_q  <= 1'b0;
         clr_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         up_q  <= ref_early | (up_q & ~clr_q);
         dn_q  <= fb_early  | (dn_q & ~clr_q);
         // clear enable lags the both-set condition by one cycle
         clr_q <= up_q & dn_q & ~clr_q;
         if (clr_q)
            cnt_q <= '0;
         else if ((up_q ^ dn_q) && (cnt_q != CNT_SAT))
            cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign up_o       = up_q;
   assign dn_o       = dn_q;
   assign done_o     = clr_q;
   assign width_ok_o = (cnt_q <= CNT_TOL);

   generate
      if (HAS_WIN) begin : g_win
         logic e1_q, e2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               e1_q <= 1'b0;
               e2_q <= 1'b0;
            end else begin
               e1_q <= ref_early;
               e2_q <= e1_q;
            end
         end
         assign win_o = en & (ref_early | e1_q | e2_q);
      end else begin : g_nowin
         assign win_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
   parameter int LOCK_RUNS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic done,
   input  logic ok,
   output logic locked_o
);
   localparam int RUN_W = $clog2(LOCK_RUNS + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_RUNS);
   localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

   logic [RUN_W-1:0] runs_q;
   logic             lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         runs_q <= '0;
         lock_q <= 1'b0;
      end else if (!en) begin
         runs_q <= '0;
         lock_q <= 1'b0;
      end else if (done) begin
         if (ok) begin
            if (runs_q != RUN_MAX)
               runs_q <= runs_q + RUN_ONE;
            lock_q <= (runs_q >= (RUN_MAX - RUN_ONE));
         end else begin
            runs_q <= '0;
            lock_q <= 1'b0;
         end
      end
   end

   assign locked_o = lock_q;
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
   parameter int LOCK_TOL  = 1,
   parameter int LOCK_RUNS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic main_en,
   input  logic aux_en,
   input  logic main_ref_div,
   input  logic main_fb_div,
   input  logic aux_ref_div,
   input  logic aux_fb_div,
   input  logic a_word_load,
   input  logic strobe,
   output logic main_up,
   output logic main_dn,
   output logic main_int_up,
   output logic main_int_dn,
   output logic aux_up,
   output logic aux_dn,
   output logic speedup,
   output logic comp_win,
   output logic lock
);
   import pfd_pkg::*;

   generate
      if (LOCK_TOL < 0) begin : g_bad_tol
         $error("LOCK_TOL must be zero or more");
      end
      if (LOCK_RUNS < 1) begin : g_bad_runs
         $error("LOCK_RUNS must be at least one");
      end
   endgenerate

   logic [NUM_CH-1:0] en_v, ref_v, fb_v, ch_lock, win_v;
   pump_t             pump [NUM_CH];

   assign en_v[CH_MAIN]  = main_en;
   assign en_v[CH_AUX]   = aux_en;
   assign ref_v[CH_MAIN] = main_ref_div;
   assign ref_v[CH_AUX]  = aux_ref_div;
   assign fb_v[CH_MAIN]  = main_fb_div;
   assign fb_v[CH_AUX]   = aux_fb_div;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic ref_early, fb_early, done, ok, up, dn, locked;

         pfd_fall_tap u_ref_tap (
            .clk(clk), .rst_n(rst_n), .pulse_i(ref_v[ch]), .early_o(ref_early));
         pfd_fall_tap u_fb_tap (
            .clk(clk), .rst_n(rst_n), .pulse_i(fb_v[ch]), .early_o(fb_early));

         pfd_flop_pair #(
            .LOCK_TOL(LOCK_TOL),
            .HAS_WIN (ch == CH_MAIN)
         ) u_pair (
            .clk(clk), .rst_n(rst_n), .en(en_v[ch]),
            .ref_early(ref_early), .fb_early(fb_early),
            .up_o(up), .dn_o(dn), .done_o(done), .width_ok_o(ok),
            .win_o(win_v[ch]));

         pfd_lock_qual #(.LOCK_RUNS(LOCK_RUNS)) u_qual (
            .clk(clk), .rst_n(rst_n), .en(en_v[ch]),
            .done(done), .ok(ok), .locked_o(locked));

         assign pump[ch].up = up;
         assign pump[ch].dn = dn;
         assign ch_lock[ch] = ~en_v[ch] | locked;
      end
   endgenerate

   logic sp_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp_q <= 1'b0;
      else        sp_q <= strobe & (sp_q | a_word_load);
   end

   assign main_up     = pump[CH_MAIN].up;
   assign main_dn     = pump[CH_MAIN].dn;
   assign aux_up      = pump[CH_AUX].up;
   assign aux_dn      = pump[CH_AUX].dn;
   assign speedup     = sp_q;
   assign main_int_up = pump[CH_MAIN].up & sp_q;
   assign main_int_dn = pump[CH_MAIN].dn & sp_q;
   assign comp_win    = |win_v;
   assign lock        = &ch_lock;
endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk (
   input logic clk,
   input logic rst_n,
   input logic main_en,
   input logic aux_en,
   input logic a_word_load,
   input logic strobe,
   input logic main_up,
   input logic main_dn,
   input logic main_int_up,
   input logic main_int_dn,
   input logic aux_up,
   input logic aux_dn,
   input logic speedup,
   input logic comp_win
);
   // R3: an overlap lasts two cycles and then releases
   a_r3_main_overlap_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (main_up && main_dn && $past(main_up && main_dn)) |=> !(main_up && main_dn));
   a_r3_aux_overlap_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_up && aux_dn && $past(aux_up && aux_dn)) |=> !(aux_up && aux_dn));

   // R4: a disabled channel drives no pump
   a_r4_main_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_en && $past(!main_en)) |-> (!main_up && !main_dn));
   a_r4_aux_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!aux_en && $past(!aux_en)) |-> (!aux_up && !aux_dn));

   // R1: up can only rise while the channel was enabled
   a_r1_up_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_up) |-> $past(main_en));

   // R8: window spans three cycles
   a_r8_win_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(comp_win) && main_en) |=> comp_win);
   a_r8_win_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_win && $past(comp_win) && $past(comp_win, 2)) |=> !comp_win);

   // R9: speed-up entry and exit
   a_r9_sp_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(speedup) |-> $past(a_word_load && strobe));
   a_r9_sp_exit: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> !speedup);

   // R10: integral enables only in speed-up
   a_r10_int_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (main_int_up || main_int_dn) |-> speedup);
endmodule

bind dual_pfd_lock dual_pfd_lock_chk u_chk (.*);

// File: tb/dual_pfd_lock_tb.sv
module dual_pfd_lock_tb;
   localparam int TOL  = 1;
   localparam int RUNS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic main_en = 1'b1, aux_en = 1'b1;
   logic main_ref_div = 1'b1, main_fb_div = 1'b1;
   logic aux_ref_div = 1'b1, aux_fb_div = 1'b1;
   logic a_word_load = 1'b0, strobe = 1'b0;
   logic main_up, main_dn, main_int_up, main_int_dn;
   logic aux_up, aux_dn, speedup, comp_win, lock;

   always #2.5 clk = ~clk;

   dual_pfd_lock #(.LOCK_TOL(TOL), .LOCK_RUNS(RUNS)) u_dut (.*);

   int total = 0;
   int bad   = 0;
   bit done_flag = 0;

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
      end
   endtask

   // behavioural reference model, indexed 0 = main, 1 = aux
   int m_last_r[2], m_last_f[2];
   int m_er[2], m_ef[2];
   int m_up[2], m_dn[2], m_clr[2], m_w[2], m_runs[2], m_lk[2];
   int m_e1, m_e2, m_sp;

   always @(posedge clk) begin
      int in_r[2], in_f[2], en[2];
      in_r[0] = main_ref_div; in_r[1] = aux_ref_div;
      in_f[0] = main_fb_div;  in_f[1] = aux_fb_div;
      en[0]   = main_en;      en[1]   = aux_en;
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_last_r[c] = 1; m_last_f[c] = 1; m_er[c] = 0; m_ef[c] = 0;
            m_up[c] = 0; m_dn[c] = 0; m_clr[c] = 0; m_w[c] = 0;
            m_runs[c] = 0; m_lk[c] = 0;
         end
         m_e1 = 0; m_e2 = 0; m_sp = 0;
      end else begin
         m_e2 = m_e1;
         m_e1 = m_er[0];
         m_sp = strobe && (m_sp || a_word_load);
         for (int c = 0; c < 2; c++) begin
            int oe_r, oe_f, up, dn, clr, w;
            oe_r = m_er[c]; oe_f = m_ef[c];
            up = m_up[c]; dn = m_dn[c]; clr = m_clr[c]; w = m_w[c];
            m_er[c] = (m_last_r[c] == 1 && in_r[c] == 0);
            m_ef[c] = (m_last_f[c] == 1 && in_f[c] == 0);
            m_last_r[c] = in_r[c]; m_last_f[c] = in_f[c];
            if (!en[c]) begin
               m_up[c] = 0; m_dn[c] = 0; m_clr[c] = 0; m_w[c] = 0;
               m_runs[c] = 0; m_lk[c] = 0;
            end else begin
               m_up[c]  = oe_r || (up && !clr);
               m_dn[c]  = oe_f || (dn && !clr);
               m_clr[c] = up && dn && !clr;
               if (clr) m_w[c] = 0;
               else if (up != dn && w < TOL + 1) m_w[c] = w + 1;
               if (clr) begin
                  if (w <= TOL) begin
                     if (m_runs[c] < RUNS) m_runs[c]++;
                     m_lk[c] = (m_runs[c] >= RUNS);
                  end else begin
                     m_runs[c] = 0; m_lk[c] = 0;
                  end
               end
            end
         end
      end
   end

   // per-cycle comparison, half a cycle after the active edge
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk("R1", "main_up", main_up, 1'(m_up[0]));
         chk("R2", "main_dn", main_dn, 1'(m_dn[0]));
         chk("R1", "aux_up",  aux_up,  1'(m_up[1]));
         chk("R2", "aux_dn",  aux_dn,  1'(m_dn[1]));
         chk("R9", "speedup", speedup, 1'(m_sp));
         chk("R10", "main_int_up", main_int_up, 1'(m_up[0] && m_sp));
         chk("R10", "main_int_dn", main_int_dn, 1'(m_dn[0] && m_sp));
         chk("R8", "comp_win", comp_win, 1'(main_en && (m_er[0] || m_e1 || m_e2)));
         chk("R7", "lock", lock, 1'((!main_en || m_lk[0]) && (!aux_en || m_lk[1])));
      end
   end

   // sixteen-cycle periods, pulses two cycles low at given offsets (-1: none)
   task automatic run_per(input int n, input int mro, input int mfo,
                          input int aro, input int afo, input int mro2);
      for (int p = 0; p < n; p++) begin
         for (int t = 0; t < 16; t++) begin
            @(negedge clk); #1;
            main_ref_div = !((mro  >= 0 && t >= mro  && t < mro  + 2) ||
                             (mro2 >= 0 && t >= mro2 && t < mro2 + 2));
            main_fb_div  = !(mfo >= 0 && t >= mfo && t < mfo + 2);
            aux_ref_div  = !(aro >= 0 && t >= aro && t < aro + 2);
            aux_fb_div   = !(afo >= 0 && t >= afo && t < afo + 2);
         end
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk("R1", "reset main_up", main_up, 1'b0);
      chk("R2", "reset main_dn", main_dn, 1'b0);
      chk("R9", "reset speedup", speedup, 1'b0);
      chk("R6", "reset lock", lock, 1'b0);
      #1 rst_n = 1'b1;

      // aligned on both channels: lock after two passing comparisons
      run_per(5, 2, 2, 4, 4, -1);
      chk("R6", "lock after aligned run", lock, 1'b1);

      // main feedback one cycle late: still within tolerance
      run_per(3, 2, 3, 4, 4, -1);
      chk("R5", "lock with one-cycle lag", lock, 1'b1);

      // main feedback three cycles late: fails
      run_per(2, 2, 5, 4, 4, -1);
      chk("R5", "lock with three-cycle lag", lock, 1'b0);

      // feedback leading by two: down wider, still out of lock
      run_per(3, 4, 2, 4, 4, -1);
      chk("R6", "lock with feedback leading", lock, 1'b0);

      // aux disabled with noise, main aligned
      aux_en = 1'b0;
      run_per(4, 2, 2, 3, 9, -1);
      chk("R4", "aux_up while disabled", aux_up, 1'b0);
      chk("R7", "lock with aux disabled", lock, 1'b1);

      // speed-up entry during aligned run
      aux_en = 1'b1;
      @(negedge clk); #1 strobe = 1'b1; a_word_load = 1'b1;
      @(negedge clk); #1 a_word_load = 1'b0;
      chk("R9", "speedup after load", speedup, 1'b1);
      run_per(2, 2, 3, 4, 4, -1);
      chk("R9", "speedup held", speedup, 1'b1);
      strobe = 1'b0;
      @(negedge clk);
      chk("R9", "speedup after strobe low", speedup, 1'b0);
      #1 a_word_load = 1'b1;
      @(negedge clk); #1 a_word_load = 1'b0;
      chk("R9", "load ignored with strobe low", speedup, 1'b0);
      run_per(1, 2, 2, 4, 4, -1);
      chk("R10", "integral up off in normal mode", main_int_up, 1'b0);

      // main disabled, aux aligned
      main_en = 1'b0;
      run_per(3, 1, 8, 4, 4, -1);
      chk("R4", "main_up while disabled", main_up, 1'b0);
      chk("R7", "lock with main disabled", lock, 1'b1);

      // frequency error: two reference pulses per feedback pulse
      main_en = 1'b1;
      run_per(3, 1, 1, 4, 4, 8);
      chk("R6", "lock with frequency error", lock, 1'b0);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule